// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small set of shared ownership tokens that two ports, left and right, use for software handshaking around a shared resource. Each port selects one token by index while its active-low semaphore select is low. A write with data bit 0 asks for the token and a write with data bit 1 hands it back. A read shows the port whether it holds the token. A token never has more than one owner.

A request for a token that the other port holds is not lost. It stays pending inside the block, and the token passes to the waiting port on the same clock edge that the owner releases it. When both ports ask for the same free token in the same cycle, the left port gets it. State changes on the rising clock edge. Readback is combinational from the registered ownership and the port's current select and index.

Top module: `sem_unit`

## Requirements
- R1: After reset every token is free, and both ports read 1 at every index.
- R2: A write of 0 to a free token (select low, write strobe high) makes the writing port its owner from the next clock edge. The owner then reads 0 at that index and the other port reads 1.
- R3: A write strobe while the port's select is high, or a read with the write strobe low, changes no token.
- R4: No token is ever owned by both ports at once.
- R5: A write of 1 by the owner frees the token. A write of 1 by a port that does not own the token has no effect.
- R6: When both ports write 0 to the same free token in the same cycle, the left port becomes its owner.
- R7: A write of 0 to a token that the other port owns leaves ownership unchanged and records a pending request. When the owner releases the token, ownership passes to the waiting port on that same edge.
- R8: The 3-bit index selects exactly one token. An access to one index leaves every other token unchanged.
- R9: While a port's select is high, its readback is 1 whatever the ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_idx_i | input | 3 | Left token index |
| l_we_i | input | 1 | Left write strobe |
| l_wdata_i | input | 1 | Left write bit: 0 requests, 1 releases |
| l_rdata_o | output | 1 | Left readback: 0 when the left port owns the token |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_idx_i | input | 3 | Right token index |
| r_we_i | input | 1 | Right write strobe |
| r_wdata_i | input | 1 | Right write bit: 0 requests, 1 releases |
| r_rdata_o | output | 1 | Right readback: 0 when the right port owns the token |

## Verification
Every index is taken through four orderings. The first is a lone left request followed by a release. The second is a right request against a left-held token, with a stray write of 1 from the right, then a handoff. The third is a request from each port in the same cycle. The fourth is a series of writes with the select high. After each step the bench reads all eight tokens from both ports and compares them with its own ownership model. These orderings separate a plain grant from a queued grant, and a priority error from a lost pending request. The full sweep also exposes index decode faults that disturb neighbouring tokens. A separate read with the select high shows whether readback is gated by the select or leaks ownership.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int N_SEM = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             sem_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             we_i,
  input  logic             wdata_i,
  output logic [N_SEM-1:0] req_o,
  output logic [N_SEM-1:0] rel_o
);
  for (genvar i = 0; i < N_SEM; i++) begin : g_dec
    logic hit;
    assign hit      = !sem_ni && we_i && (idx_i == IDX_W'(i));
    assign req_o[i] = hit && !wdata_i;
    assign rel_o[i] = hit && wdata_i;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_req_i,
  input  logic l_rel_i,
  input  logic r_req_i,
  input  logic r_rel_i,
  output logic own_l_o,
  output logic own_r_o,
  output logic pend_l_o,
  output logic pend_r_o
);
  owner_e owner_q, owner_d;
  logic   pl_q, pr_q, pl_d, pr_d;
  logic   l_want, r_want;

  always_comb begin
    l_want  = pl_q || (l_req_i && owner_q != OWN_L);
    r_want  = pr_q || (r_req_i && owner_q != OWN_R);
    owner_d = owner_q;
    if (owner_q == OWN_L && l_rel_i) owner_d = OWN_FREE;
    if (owner_q == OWN_R && r_rel_i) owner_d = OWN_FREE;
    // left has priority on a free token
    if (owner_d == OWN_FREE) begin
      if (l_want)      owner_d = OWN_L;
      else if (r_want) owner_d = OWN_R;
    end
    pl_d = l_want && owner_d != OWN_L;
    pr_d = r_want && owner_d != OWN_R;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_FREE;
      pl_q    <= 1'b0;
      pr_q    <= 1'b0;
    end else begin
      owner_q <= owner_d;
      pl_q    <= pl_d;
      pr_q    <= pr_d;
    end
  end

  assign own_l_o  = owner_q == OWN_L;
  assign own_r_o  = owner_q == OWN_R;
  assign pend_l_o = pl_q;
  assign pend_r_o = pr_q;
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int N_SEM = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l_sem_ni,
  input  logic [IDX_W-1:0] l_idx_i,
  input  logic             l_we_i,
  input  logic             l_wdata_i,
  output logic             l_rdata_o,
  input  logic             r_sem_ni,
  input  logic [IDX_W-1:0] r_idx_i,
  input  logic             r_we_i,
  input  logic             r_wdata_i,
  output logic             r_rdata_o
);
  logic [N_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [N_SEM-1:0] own_l, own_r, pend_l, pend_r;

  sem_port_dec #(.N_SEM(N_SEM)) u_dec_l (
    .sem_ni(l_sem_ni), .idx_i(l_idx_i), .we_i(l_we_i), .wdata_i(l_wdata_i),
    .req_o(l_req), .rel_o(l_rel)
  );

  sem_port_dec #(.N_SEM(N_SEM)) u_dec_r (
    .sem_ni(r_sem_ni), .idx_i(r_idx_i), .we_i(r_we_i), .wdata_i(r_wdata_i),
    .req_o(r_req), .rel_o(r_rel)
  );

  for (genvar i = 0; i < N_SEM; i++) begin : g_cell
    sem_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .l_req_i (l_req[i]),
      .l_rel_i (l_rel[i]),
      .r_req_i (r_req[i]),
      .r_rel_i (r_rel[i]),
      .own_l_o (own_l[i]),
      .own_r_o (own_r[i]),
      .pend_l_o(pend_l[i]),
      .pend_r_o(pend_r[i])
    );
  end

  // 0 = this port holds the token
  assign l_rdata_o = l_sem_ni ? 1'b1 : !own_l[l_idx_i];
  assign r_rdata_o = r_sem_ni ? 1'b1 : !own_r[r_idx_i];
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int N_SEM = 8,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             l_sem_ni,
  input logic [IDX_W-1:0] l_idx_i,
  input logic             l_we_i,
  input logic             l_wdata_i,
  input logic             r_sem_ni,
  input logic [IDX_W-1:0] r_idx_i,
  input logic             r_we_i,
  input logic             r_wdata_i,
  input logic [N_SEM-1:0] own_l,
  input logic [N_SEM-1:0] own_r,
  input logic [N_SEM-1:0] pend_l,
  input logic [N_SEM-1:0] pend_r
);
  logic l_wr, r_wr;
  assign l_wr = !l_sem_ni && l_we_i;
  assign r_wr = !r_sem_ni && r_we_i;

  p_mutex_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  p_owner_not_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((own_l & pend_l) | (own_r & pend_r)) == '0);

  p_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_wr && !r_wr) |=> ($stable(own_l) && $stable(own_r)));

  p_left_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr && !l_wdata_i && !own_l[l_idx_i] && !own_r[l_idx_i])
    |=> own_l[$past(l_idx_i)]);

  p_right_yield_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr && !l_wdata_i && r_wr && !r_wdata_i && l_idx_i == r_idx_i
     && !own_l[l_idx_i] && !own_r[l_idx_i])
    |=> (own_l[$past(l_idx_i)] && pend_r[$past(l_idx_i)]));

  p_handoff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr && l_wdata_i && own_l[l_idx_i] && pend_r[l_idx_i])
    |=> own_r[$past(l_idx_i)]);

  p_handoff_left_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr && r_wdata_i && own_r[r_idx_i] && pend_l[r_idx_i]
     && !(l_wr && l_idx_i == r_idx_i))
    |=> own_l[$past(r_idx_i)]);

  p_foreign_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr && r_wdata_i && own_l[r_idx_i] && !(l_wr && l_idx_i == r_idx_i))
    |=> own_l[$past(r_idx_i)]);
endmodule

bind sem_unit sem_unit_chk #(.N_SEM(N_SEM)) u_chk (.*);

// File: tb/sem_unit_tb.sv
`timescale 1ns/1ps
module sem_unit_tb;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_n = 1'b1, l_we = 1'b0, l_wd = 1'b0;
  logic r_sem_n = 1'b1, r_we = 1'b0, r_wd = 1'b0;
  logic [2:0] l_idx = '0, r_idx = '0;
  logic l_rd, r_rd;
  int checks = 0, errors = 0;
  int exp_own [N];  // 0 free, 1 left, 2 right
  bit done = 1'b0;

  always #4 clk = ~clk;

  sem_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_ni(l_sem_n), .l_idx_i(l_idx), .l_we_i(l_we), .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_sem_ni(r_sem_n), .r_idx_i(r_idx), .r_we_i(r_we), .r_wdata_i(r_wd), .r_rdata_o(r_rd)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  // read every index from both ports, compare with model
  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      l_sem_n = 1'b0; r_sem_n = 1'b0; l_we = 1'b0; r_we = 1'b0;
      l_idx = 3'(i); r_idx = 3'(i);
      #1;
      chk(req, l_rd, exp_own[i] != 1);
      chk(req, r_rd, exp_own[i] != 2);
    end
    l_sem_n = 1'b1; r_sem_n = 1'b1;
  endtask

  task automatic wr(input bit left, input int idx, input logic d);
    @(negedge clk);
    if (left) begin l_sem_n = 1'b0; l_we = 1'b1; l_idx = 3'(idx); l_wd = d; end
    else      begin r_sem_n = 1'b0; r_we = 1'b1; r_idx = 3'(idx); r_wd = d; end
    @(negedge clk);
    l_sem_n = 1'b1; l_we = 1'b0; r_sem_n = 1'b1; r_we = 1'b0;
  endtask

  task automatic wr_both(input int idx, input logic dl, input logic dr);
    @(negedge clk);
    l_sem_n = 1'b0; l_we = 1'b1; l_idx = 3'(idx); l_wd = dl;
    r_sem_n = 1'b0; r_we = 1'b1; r_idx = 3'(idx); r_wd = dr;
    @(negedge clk);
    l_sem_n = 1'b1; l_we = 1'b0; r_sem_n = 1'b1; r_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_own[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset free");

    for (int i = 0; i < N; i++) begin
      wr(1, i, 1'b0); exp_own[i] = 1;
      check_all("R2 R8 left grant");
      wr(0, i, 1'b0);
      check_all("R7 blocked request");
      wr(0, i, 1'b1);
      check_all("R5 foreign release ignored");
      wr(1, i, 1'b1); exp_own[i] = 2;
      check_all("R7 handoff on release");
      wr(0, i, 1'b1); exp_own[i] = 0;
      check_all("R5 owner release");
      wr(0, i, 1'b0); exp_own[i] = 2;
      check_all("R2 right grant");
      wr(0, i, 1'b1); exp_own[i] = 0;
      check_all("R5 right release");
    end

    for (int i = 0; i < N; i++) begin
      wr_both(i, 1'b0, 1'b0); exp_own[i] = 1;
      check_all("R6 left wins tie");
      wr(1, i, 1'b1); exp_own[i] = 2;
      check_all("R6 R7 loser pending");
      wr(0, i, 1'b1); exp_own[i] = 0;
      check_all("R5 release after tie");
    end

    // writes with select high
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      l_sem_n = 1'b1; l_we = 1'b1; l_idx = 3'(i); l_wd = 1'b0;
      r_sem_n = 1'b1; r_we = 1'b1; r_idx = 3'(i); r_wd = 1'b0;
      @(negedge clk);
      l_we = 1'b0; r_we = 1'b0;
    end
    check_all("R3 deselected write");

    // reads only, select low
    @(negedge clk);
    l_sem_n = 1'b0; r_sem_n = 1'b0; l_we = 1'b0; r_we = 1'b0; l_wd = 1'b0; r_wd = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R3 read no effect");

    wr(1, 5, 1'b0); exp_own[5] = 1;
    wr(0, 2, 1'b0); exp_own[2] = 2;
    l_idx = 3'd5; r_idx = 3'd2; l_sem_n = 1'b1; r_sem_n = 1'b1;
    #1;
    chk("R9 left deselected read", l_rd, 1'b1);
    chk("R9 right deselected read", r_rd, 1'b1);
    l_sem_n = 1'b0; r_sem_n = 1'b0;
    #1;
    chk("R2 left owner read", l_rd, 1'b0);
    chk("R2 right owner read", r_rd, 1'b0);
    l_sem_n = 1'b1; r_sem_n = 1'b1;
    check_all("R4 R8 two owners");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule